// File: doc/BRIEF.md
# Dual-Port Shared Mailbox Memory

This block is a shared word store that two agents reach through their own ports, A and B. Each port has its own address, select, write strobe, output strobe, write data and read data. Either side can read or write at any moment, and both work at full rate whenever their addresses differ. The design is synchronous on a single clock. In place of three-state pins, each port has a data-out-enable that tells the surrounding logic when the read data should drive a shared bus.

When both ports select the same word, an arbiter picks one of them to proceed. It holds the other off by suppressing that port's write, and it raises that port's active-low not-ready flag on the next cycle. The port that reached the word first keeps it. If both reach it in the same cycle, port A wins. A port that has won keeps the word for as long as the collision lasts.

Top module: `mbox_dpram`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, both read-data outputs are 0, both data-out-enables are 0 and both not-ready outputs are 1 (idle).
- R2: A port whose select (`*_cs_n`) and write strobe (`*_we_n`) are both 0 on a clock edge, and which is not blocked, stores its write data at its address on that edge.
- R3: A port with its select at 0 on an edge presents, after that edge, the word its address held before that edge (read-first). With its select at 1, its read data holds its previous value.
- R4: A port's data-out-enable is 1 after an edge exactly when, on that edge, its select and output strobe were 0 and its write strobe was 1. Otherwise it is 0.
- R5: A word written through one port is returned by a read through the other port.
- R6: When both ports become selected on the same address on the same edge, and neither was on that address the cycle before, port A wins. Port B's write on that edge is discarded.
- R7: When one port was selected on an address on the previous edge and the other port now selects the same address, the earlier port wins and the newcomer is blocked.
- R8: While the collision continues on consecutive edges, the port that won keeps winning.
- R9: A port's not-ready output is 0 after an edge on which that port was blocked. It returns to 1 after the first edge on which the addresses differ or either port is deselected. The two not-ready outputs are never both 0.
- R10: Selected accesses from both ports to different addresses on the same edge all take effect, and neither port raises not-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_cs_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output strobe, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_doe | output | 1 | Port A data-out-enable |
| a_rdy_n | output | 1 | Port A not-ready, active low |
| b_cs_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output strobe, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_doe | output | 1 | Port B data-out-enable |
| b_rdy_n | output | 1 | Port B not-ready, active low |

## Verification
A write lands in the array on the edge where it is presented, so a read of that word is due on the edge after it. Read data, data-out-enable and not-ready all change one edge after the inputs that cause them, and not-ready clears one edge after the collision ends. The bench drives inputs on the falling edge and compares every output at the next falling edge, against a behavioural model that advances on the rising edge in between. Each result is therefore sampled exactly one rising edge after its stimulus.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;
endpackage

// File: rtl/mbox_arb.sv
module mbox_arb
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_act,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_act,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              a_blk,
  output logic              b_blk
);
  owner_e            owner_q, owner_d, winner;
  logic              a_act_q, b_act_q;
  logic [ADDR_W-1:0] a_addr_q, b_addr_q;
  logic              clash, a_stay, b_stay;

  assign clash  = a_act && b_act && (a_addr == b_addr);
  assign a_stay = a_act_q && (a_addr_q == a_addr);
  assign b_stay = b_act_q && (b_addr_q == b_addr);

  always_comb begin
    winner = OWN_A;
    if (owner_q != OWN_NONE)   winner = owner_q;
    else if (b_stay && !a_stay) winner = OWN_B;
    owner_d = clash ? winner : OWN_NONE;
  end

  assign a_blk = clash && (winner == OWN_B);
  assign b_blk = clash && (winner == OWN_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= OWN_NONE;
      a_act_q  <= 1'b0;
      b_act_q  <= 1'b0;
      a_addr_q <= '0;
      b_addr_q <= '0;
    end else begin
      owner_q  <= owner_d;
      a_act_q  <= a_act;
      b_act_q  <= b_act;
      a_addr_q <= a_addr;
      b_addr_q <= b_addr;
    end
  end
endmodule

// File: rtl/mbox_mem.sv
module mbox_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       a_rdata <= '0;
    else if (a_en) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)       b_rdata <= '0;
    else if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/mbox_port_flags.sv
module mbox_port_flags (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic oe_n,
  input  logic we_n,
  input  logic blk,
  output logic doe,
  output logic rdy_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      doe   <= 1'b0;
      rdy_n <= 1'b1;
    end else begin
      doe   <= act && !oe_n && we_n;
      rdy_n <= !blk;
    end
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_cs_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_doe,
  output logic              a_rdy_n,
  input  logic              b_cs_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_doe,
  output logic              b_rdy_n
);
  logic a_act, b_act, a_blk, b_blk, a_wr, b_wr;

  assign a_act = !a_cs_n;
  assign b_act = !b_cs_n;
  assign a_wr  = a_act && !a_we_n && !a_blk;
  assign b_wr  = b_act && !b_we_n && !b_blk;

  mbox_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst(rst),
    .a_act(a_act), .a_addr(a_addr),
    .b_act(b_act), .b_addr(b_addr),
    .a_blk(a_blk), .b_blk(b_blk)
  );

  mbox_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst),
    .a_en(a_act), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_act), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  mbox_port_flags u_flags_a (
    .clk(clk), .rst(rst), .act(a_act), .oe_n(a_oe_n), .we_n(a_we_n),
    .blk(a_blk), .doe(a_doe), .rdy_n(a_rdy_n)
  );

  mbox_port_flags u_flags_b (
    .clk(clk), .rst(rst), .act(b_act), .oe_n(b_oe_n), .we_n(b_we_n),
    .blk(b_blk), .doe(b_doe), .rdy_n(b_rdy_n)
  );
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              a_cs_n,
  input logic              a_we_n,
  input logic              a_oe_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_doe,
  input logic              a_rdy_n,
  input logic              b_cs_n,
  input logic              b_we_n,
  input logic              b_oe_n,
  input logic [ADDR_W-1:0] b_addr,
  input logic              b_doe,
  input logic              b_rdy_n
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (a_rdy_n && b_rdy_n && !a_doe && !b_doe));

  assert_doe_cause_R4: assert property (@(posedge clk) disable iff (rst)
    a_doe |-> $past(!a_cs_n && !a_oe_n && a_we_n));

  assert_doe_cause_b_R4: assert property (@(posedge clk) disable iff (rst)
    b_doe |-> $past(!b_cs_n && !b_oe_n && b_we_n));

  assert_one_loser_R9: assert property (@(posedge clk) disable iff (rst)
    !(!a_rdy_n && !b_rdy_n));

  assert_deselect_frees_b_R9: assert property (@(posedge clk) disable iff (rst)
    a_cs_n |=> b_rdy_n);

  assert_deselect_frees_a_R9: assert property (@(posedge clk) disable iff (rst)
    b_cs_n |=> a_rdy_n);

  assert_no_stall_apart_R10: assert property (@(posedge clk) disable iff (rst)
    (!a_cs_n && !b_cs_n && (a_addr != b_addr)) |=> (a_rdy_n && b_rdy_n));
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst),
  .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
  .a_doe(a_doe), .a_rdy_n(a_rdy_n),
  .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
  .b_doe(b_doe), .b_rdy_n(b_rdy_n)
);

// File: tb/sim_mbox_dpram.sv
module sim_mbox_dpram;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a_cs_n = 1'b1, a_we_n = 1'b1, a_oe_n = 1'b1;
  logic [7:0] a_addr = '0, a_wdata = '0;
  logic [7:0] a_rdata;
  logic       a_doe, a_rdy_n;
  logic       b_cs_n = 1'b1, b_we_n = 1'b1, b_oe_n = 1'b1;
  logic [7:0] b_addr = '0, b_wdata = '0;
  logic [7:0] b_rdata;
  logic       b_doe, b_rdy_n;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_dpram u0 (
    .clk(clk), .rst(rst),
    .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_doe(a_doe), .a_rdy_n(a_rdy_n),
    .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_doe(b_doe), .b_rdy_n(b_rdy_n)
  );

  // Behavioural reference model, advanced on each rising edge
  int  m_mem [256];
  bit  m_known [256];
  int  m_owner = 0;          // 0 nobody, 1 A, 2 B
  bit  m_pa = 0, m_pb = 0;
  int  m_paddr = 0, m_pbaddr = 0;
  int  e_ard = 0, e_brd = 0;
  bit  e_akn = 1, e_bkn = 1;
  bit  e_adoe = 0, e_bdoe = 0, e_ardy = 1, e_brdy = 1;

  always @(posedge clk) begin
    bit ua, ub, hit, lose_a, lose_b;
    int win;
    if (rst) begin
      m_owner = 0; m_pa = 0; m_pb = 0; m_paddr = 0; m_pbaddr = 0;
      e_ard = 0; e_brd = 0; e_akn = 1; e_bkn = 1;
      e_adoe = 0; e_bdoe = 0; e_ardy = 1; e_brdy = 1;
    end else begin
      ua  = !a_cs_n;
      ub  = !b_cs_n;
      hit = ua && ub && (a_addr == b_addr);
      if (m_owner != 0) win = m_owner;
      else if (m_pb && m_pbaddr == int'(b_addr) && !(m_pa && m_paddr == int'(a_addr))) win = 2;
      else win = 1;
      lose_a = hit && win == 2;
      lose_b = hit && win == 1;
      if (ua) begin e_ard = m_mem[a_addr]; e_akn = m_known[a_addr]; end
      if (ub) begin e_brd = m_mem[b_addr]; e_bkn = m_known[b_addr]; end
      if (ua && !a_we_n && !lose_a) begin m_mem[a_addr] = a_wdata; m_known[a_addr] = 1; end
      if (ub && !b_we_n && !lose_b) begin m_mem[b_addr] = b_wdata; m_known[b_addr] = 1; end
      e_adoe = ua && !a_oe_n && a_we_n;
      e_bdoe = ub && !b_oe_n && b_we_n;
      e_ardy = !lose_a;
      e_brdy = !lose_b;
      m_owner = hit ? win : 0;
      m_pa = ua; m_pb = ub; m_paddr = a_addr; m_pbaddr = b_addr;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, on the falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (e_akn) chk("R3 a_rdata", a_rdata, e_ard);
      if (e_bkn) chk("R3 b_rdata", b_rdata, e_brd);
      chk("R4 a_doe", a_doe, e_adoe);
      chk("R4 b_doe", b_doe, e_bdoe);
      chk("R9 a_rdy_n", a_rdy_n, e_ardy);
      chk("R9 b_rdy_n", b_rdy_n, e_brdy);
    end
  end

  task automatic port_a(bit cs, bit we, bit oe, logic [7:0] ad, logic [7:0] d);
    a_cs_n = !cs; a_we_n = !we; a_oe_n = !oe; a_addr = ad; a_wdata = d;
  endtask

  task automatic port_b(bit cs, bit we, bit oe, logic [7:0] ad, logic [7:0] d);
    b_cs_n = !cs; b_we_n = !we; b_oe_n = !oe; b_addr = ad; b_wdata = d;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    port_a(0, 0, 0, 8'h00, 8'h00);
    port_b(0, 0, 0, 8'h00, 8'h00);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_mem[i] = 0; m_known[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 a_rdata", a_rdata, 0);
    chk("R1 b_rdata", b_rdata, 0);
    chk("R1 a_doe", a_doe, 0);
    chk("R1 b_doe", b_doe, 0);
    chk("R1 a_rdy_n", a_rdy_n, 1);
    chk("R1 b_rdy_n", b_rdy_n, 1);
    rst = 1'b0;
    step();
    chk("R1 idle a_rdy_n after reset", a_rdy_n, 1);
    chk("R1 idle b_doe after reset", b_doe, 0);

    // R2: A writes, then A reads back
    port_a(1, 1, 0, 8'h10, 8'h5A); step();
    port_a(1, 0, 1, 8'h10, 8'h00); step();
    chk("R2 A write read back", a_rdata, 8'h5A);
    chk("R4 A doe on read", a_doe, 1);
    // R5: B reads the word A wrote, and A reads a word B wrote
    idle(); port_b(1, 0, 1, 8'h10, 8'h00); step();
    chk("R5 B sees A write", b_rdata, 8'h5A);
    port_b(1, 1, 1, 8'h11, 8'hC3); step();
    chk("R4 B doe off while writing", b_doe, 0);
    idle(); port_a(1, 0, 1, 8'h11, 8'h00); step();
    chk("R5 A sees B write", a_rdata, 8'hC3);
    port_a(1, 0, 0, 8'h11, 8'h00); step();
    chk("R4 doe off with oe high", a_doe, 0);

    // R6: simultaneous same-address writes, A wins
    idle(); step();
    port_a(1, 1, 0, 8'h20, 8'h11);
    port_b(1, 1, 0, 8'h20, 8'h22); step();
    chk("R6 B blocked", b_rdy_n, 0);
    chk("R6 A not blocked", a_rdy_n, 1);
    idle(); step();
    chk("R9 B ready after release", b_rdy_n, 1);
    port_b(1, 0, 1, 8'h20, 8'h00); step();
    chk("R6 winner data kept", b_rdata, 8'h11);

    // R7/R8: B holds 0x30 first, A arrives and writes
    idle(); port_a(1, 1, 0, 8'h30, 8'h77); step();
    idle(); port_b(1, 0, 1, 8'h30, 8'h00); step();
    port_a(1, 1, 0, 8'h30, 8'h99); step();
    chk("R7 newcomer A blocked", a_rdy_n, 0);
    chk("R7 first-comer B free", b_rdy_n, 1);
    port_a(1, 1, 0, 8'h30, 8'h99); step();
    chk("R8 A still blocked", a_rdy_n, 0);
    port_b(0, 0, 0, 8'h30, 8'h00); step();
    chk("R9 A ready after B leaves", a_rdy_n, 1);
    idle(); port_b(1, 0, 1, 8'h30, 8'h00); step();
    chk("R7 blocked write discarded then retried", b_rdata, 8'h99);

    // R10: different addresses concurrently
    idle();
    port_a(1, 1, 0, 8'h50, 8'hA5);
    port_b(1, 1, 0, 8'h51, 8'h5A); step();
    chk("R10 A no stall", a_rdy_n, 1);
    chk("R10 B no stall", b_rdy_n, 1);
    port_a(1, 0, 1, 8'h51, 8'h00);
    port_b(1, 0, 1, 8'h50, 8'h00); step();
    chk("R10 A write landed", b_rdata, 8'hA5);
    chk("R10 B write landed", a_rdata, 8'h5A);

    // Random traffic on a few addresses to force collisions
    for (int n = 0; n < 2000; n++) begin
      port_a($urandom_range(3) != 0, $urandom_range(1), $urandom_range(1),
             8'h40 + 8'($urandom_range(3)), 8'($urandom));
      port_b($urandom_range(3) != 0, $urandom_range(1), $urandom_range(1),
             8'h40 + 8'($urandom_range(3)), 8'($urandom));
      step();
    end
    idle(); step();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule